// File: doc/BRIEF.md
# Dual-Bank Level-Sensitive Holding Register with Output Gating

The block holds two independent 9-bit banks of data. Each bank has a transparent mode and a hold mode. While a bank's load enable is high, the bank passes its data input straight to its output in the same cycle. When the load enable drops, the bank keeps the word it last took in. The storage is sampled on a system clock, so the design has no real latches. A bank loads at every rising clock edge at which its load enable is high. Its output shows the loaded word once the enable is low.

Each bank also has an active-low output enable. The high-impedance state is modelled as a per-bank drive flag plus a data value. The value means nothing while the flag is low. After reset a bank does not drive, even when its output enable is already low. The bank is armed only after its output enable has been seen inactive (high) at a rising clock edge. From then on the drive flag follows the inverse of the output enable in the same cycle.

The stored word of each bank is also brought out, so that a test wrapper can observe it. Loading continues whether or not the bank is driving.

Top module: `dual_latch_tristate`

## Requirements
- R1: While rst_ni is low, both drive flags are 0 and both stored words (held_o) are 0.
- R2: While a bank's load enable is 1, that bank's q_o slice equals its d_i slice in the same cycle.
- R3: At each rising clk edge with a bank's load enable at 1, that bank's stored word takes its d_i slice. A data change applied in the same cycle that the load enable falls is not stored, so the earlier word is held.
- R4: While a bank's load enable is 0, its q_o slice and stored word keep the last stored value, whatever d_i does.
- R5: While a bank's oe_n_i bit is 1, its drive flag is 0.
- R6: Once a bank is armed, its drive flag is 1 in every cycle in which its oe_n_i bit is 0, and q_o then carries the bank's value.
- R7: A bank that is not driving still loads data. When it is enabled later, it shows the word loaded while it was off.
- R8: After reset, a bank's drive flag stays 0 while oe_n_i is held low, until the bank has seen oe_n_i = 1 at a rising clk edge. The bank then stays armed until the next reset.
- R9: Each bank's load enable, output enable and data affect only that bank's outputs. Bank A is bit 0 of le_i, oe_n_i and drive_o, and bits 8:0 of the data ports. Bank B is bit 1 and bits 17:9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| d_i | input | NUM_BANKS*BANK_W (18) | Data in, bank b at bits b*BANK_W +: BANK_W |
| le_i | input | NUM_BANKS (2) | Load enable per bank, active high |
| oe_n_i | input | NUM_BANKS (2) | Output enable per bank, active low |
| q_o | output | NUM_BANKS*BANK_W (18) | Bank output value, valid only while its drive flag is 1 |
| drive_o | output | NUM_BANKS (2) | Per-bank drive flag; 0 models high impedance |
| held_o | output | NUM_BANKS*BANK_W (18) | Stored word per bank, for observation |

## Verification
Two events can land in the same cycle: the fall of a bank's load enable and a change of that bank's data. The bench provokes this by driving both on the same falling clock edge. It then expects the output to show the word stored before the change. The first enable of a bank after reset can also coincide with reset release while oe_n_i is already low. The bench holds oe_n_i low across reset and for several cycles after it, and requires the drive flag to stay 0 until a high sample has armed the bank. A pseudo-random sweep over both banks' controls and data covers every mix of these cases. Each cycle is judged against a model built from the requirements.

// File: rtl/dl_pkg.sv
package dl_pkg;
  localparam int DL_BANK_W    = 9;
  localparam int DL_NUM_BANKS = 2;
endpackage

// File: rtl/dl_bank_latch.sv
module dl_bank_latch #(
  parameter int W = dl_pkg::DL_BANK_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         le_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] hold_o,
  output logic [W-1:0] q_o
);
  logic [W-1:0] hold_q;

  // sampled storage: last word seen while enable high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   hold_q <= '0;
    else if (le_i) hold_q <= d_i;
  end

  assign hold_o = hold_q;
  assign q_o    = le_i ? d_i : hold_q;

  AST_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    le_i |=> (hold_o == $past(d_i)));  // R3
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !le_i |=> $stable(hold_o));  // R4
endmodule

// File: rtl/dl_powerup_gate.sv
module dl_powerup_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oe_n_i,
  output logic drive_o
);
  logic armed_q;

  // armed once output enable is sampled inactive
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= armed_q | oe_n_i;
  end

  assign drive_o = armed_q & ~oe_n_i;

  AST_OFF_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_n_i |-> !drive_o);  // R5
  AST_ARM_NEEDS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(armed_q) |-> $past(oe_n_i));  // R8
  AST_ARM_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |=> armed_q);  // R8
endmodule

// File: rtl/dual_latch_tristate.sv
module dual_latch_tristate #(
  parameter int BANK_W    = dl_pkg::DL_BANK_W,
  parameter int NUM_BANKS = dl_pkg::DL_NUM_BANKS
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_BANKS*BANK_W-1:0] d_i,
  input  logic [NUM_BANKS-1:0]        le_i,
  input  logic [NUM_BANKS-1:0]        oe_n_i,
  output logic [NUM_BANKS*BANK_W-1:0] q_o,
  output logic [NUM_BANKS-1:0]        drive_o,
  output logic [NUM_BANKS*BANK_W-1:0] held_o
);
  localparam int TOTAL_W = NUM_BANKS * BANK_W;

  logic [TOTAL_W-1:0] bank_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    dl_bank_latch #(.W(BANK_W)) u_latch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .le_i   (le_i[b]),
      .d_i    (d_i[b*BANK_W +: BANK_W]),
      .hold_o (held_o[b*BANK_W +: BANK_W]),
      .q_o    (bank_q[b*BANK_W +: BANK_W])
    );

    dl_powerup_gate u_gate (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .oe_n_i  (oe_n_i[b]),
      .drive_o (drive_o[b])
    );

    AST_TRANSPARENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      le_i[b] |-> (q_o[b*BANK_W +: BANK_W] == d_i[b*BANK_W +: BANK_W]));  // R2
    AST_DRIVE_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && $past(oe_n_i[b]) && !oe_n_i[b]) |-> drive_o[b]);  // R6
  end

  assign q_o = bank_q;
endmodule

// File: tb/dual_latch_tristate_bench.sv
`timescale 1ns/1ps
module dual_latch_tristate_bench;
  localparam int W  = 9;
  localparam int NB = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NB*W-1:0] d = '0;
  logic [NB-1:0] le = '0;
  logic [NB-1:0] oe_n = '0;
  logic [NB*W-1:0] q, held;
  logic [NB-1:0] drive;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dual_latch_tristate u_dual_latch_tristate (
    .clk_i(clk), .rst_ni(rst_n), .d_i(d), .le_i(le), .oe_n_i(oe_n),
    .q_o(q), .drive_o(drive), .held_o(held)
  );

  // reference model from the requirements
  logic [W-1:0] held_m [NB];
  logic [NB-1:0] armed_m;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NB; b++) held_m[b] <= '0;
      armed_m <= '0;
    end else begin
      for (int b = 0; b < NB; b++) if (le[b]) held_m[b] <= d[b*W +: W];
      armed_m <= armed_m | oe_n;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all();
    for (int b = 0; b < NB; b++) begin
      logic exp_drv;
      logic [W-1:0] exp_q;
      exp_drv = armed_m[b] & ~oe_n[b];
      exp_q = le[b] ? d[b*W +: W] : held_m[b];
      chk(drive[b] == exp_drv, oe_n[b] ? "R5" : (armed_m[b] ? "R6" : "R8"),
          $sformatf("drive bank%0d", b), int'(drive[b]), int'(exp_drv));
      if (exp_drv)
        chk(q[b*W +: W] == exp_q, le[b] ? "R2" : "R4",
            $sformatf("q bank%0d", b), int'(q[b*W +: W]), int'(exp_q));
      chk(held[b*W +: W] == held_m[b], "R3", $sformatf("held bank%0d", b),
          int'(held[b*W +: W]), int'(held_m[b]));
    end
  endtask

  task automatic cyc(input logic [NB*W-1:0] nd, input logic [NB-1:0] nle,
                     input logic [NB-1:0] noe);
    @(negedge clk);
    d = nd; le = nle; oe_n = noe;
    #2;
    check_all();
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(negedge clk);
    #2;
    chk(drive == '0, "R1", "drive in reset", int'(drive), 0);
    chk(held == '0, "R1", "held in reset", int'(held), 0);
    @(negedge clk); rst_n = 1'b1;
    // enable already asserted at reset: must stay undriven (R8)
    for (int i = 0; i < 5; i++) cyc({9'(i * 37), 9'(i * 11)}, 2'b11, 2'b00);
    chk(drive == 2'b00, "R8", "drive before arming", int'(drive), 0);
    cyc(18'h0, 2'b00, 2'b11);
    cyc(18'h0, 2'b00, 2'b00);
    chk(drive == 2'b11, "R8", "drive after arming", int'(drive), 3);
    // simultaneous load-enable fall and data change on bank A (R3)
    cyc({9'h000, 9'h0F0}, 2'b01, 2'b00);
    cyc({9'h000, 9'h10F}, 2'b00, 2'b00);
    chk(q[8:0] == 9'h0F0, "R3", "held word on same-cycle change", int'(q[8:0]), 'h0F0);
    // loading while disabled (R7)
    cyc({9'h000, 9'h1A5}, 2'b01, 2'b01);
    cyc({9'h000, 9'h033}, 2'b00, 2'b01);
    cyc({9'h000, 9'h044}, 2'b00, 2'b00);
    chk(drive[0] && q[8:0] == 9'h1A5, "R7", "word loaded while off",
        int'(q[8:0]), 'h1A5);
    // bank B traffic must not disturb bank A (R9)
    cyc({9'h0AA, 9'h0FF}, 2'b10, 2'b00);
    cyc({9'h155, 9'h1FF}, 2'b10, 2'b00);
    chk(q[8:0] == 9'h1A5 && q[17:9] == 9'h155, "R9", "bank isolation",
        int'(q), int'({9'h155, 9'h1A5}));
    // pseudo-random sweep over both banks
    lfsr = 32'hACE1_2345;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[30:0], 1'b0} ^ (lfsr[31] ? 32'h04C1_1DB7 : 32'h0);
      cyc(lfsr[17:0], lfsr[19:18], {lfsr[25:23] == 3'd0, lfsr[22:20] == 3'd0});
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule